// File: doc/BRIEF.md
# Context-Tagged Data TLB with Per-Entry Page Size

This block translates data virtual addresses to physical addresses through a fully associative array of entries that are all compared at once. Every entry has its own page size of 8 KB, 64 KB, 512 KB or 4 MB, and that size sets which virtual page bits take part in the compare. Every entry carries a 13-bit context tag, unless its global flag is set. A lookup supplies the virtual address, a selector that picks which context to use, the kind of access and whether the requester runs in user mode.

One clock edge after a lookup the block presents the result. On a hit this is the physical address, the write permission and the byte-swap indication. On a failed lookup it is a miss trap, a fault trap or a write-protection trap. The same edge updates the fault status word, the fault address and the tag-access value that a software miss handler reads. Entries are loaded through a plain write port. A victim index output suggests which slot to refill next.

Top module: `dtlb_top`

## Requirements
- R1: A lookup hits when some entry is valid, either has its global flag set or holds a context equal to the selected context, and matches the virtual page number on every bit that its page size does not cover. The response outputs (`rspValid`, `rspHit`, `rspPa`, the trap flags) are registered and appear on the clock edge that samples `lkValid`.
- R2: Page size code 0, 1, 2 and 3 means 8 KB, 64 KB, 512 KB and 4 MB; size code s lets VA page-number bits [3s-1:0] through. On a hit, `rspPa` takes those page-number bits from the VA and the rest from the entry's physical page number, with `rspPa[12:0]` zero.
- R3: `lkCtxSel` 0 selects `primaryCtx`, 1 selects `secondaryCtx`, and 2 or 3 select context 0. A global entry hits whatever the context.
- R4: When several entries hit, the result comes from the one with the lowest index.
- R5: A user access (`lkUser`=1) that hits a privileged entry raises `rspFault` and sets status bit 6.
- R6: A non-faulting load (`lkKind`=2) that hits a side-effect entry sets status bit 7. Any other kind that hits a no-fault-only entry sets status bit 8. Either one raises `rspFault`, and bits 6 to 8 may be set together.
- R7: A store (`lkKind`=1) to an entry without write permission and with no R5 or R6 fault raises `rspProt` and not `rspFault`. At most one of `rspMiss`, `rspFault` and `rspProt` is set.
- R8: On a fault or protection trap the status word is loaded as follows: bit 0 valid=1, bit 1 overflow = the previous valid bit, bit 2 = store, bits [4:3] = `lkCtxSel`, bit 5 = not `lkUser`, bits [8:6] = the fault types. `sfar` takes the VA, and `tagAccess` takes the VA with bits [12:0] replaced by the selected context.
- R9: On a miss, `rspMiss` is set and only `tagAccess` is updated; `sfsr` and `sfar` hold their values.
- R10: A hit with no trap sets the entry's used flag; a trapped hit does not. `victimIdx` shows the lowest invalid entry, else the lowest entry whose used flag is clear, else 0.
- R11: On a hit, `rspByteSwap` equals the entry's invert-endian flag.
- R12: A write loads the entry and clears its used flag. A lookup in the same cycle as a write sees the contents the entry had before the write.
- R13: `sfsrClr` clears the status word. When it arrives together with a fault, the new status word has overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; invalidates all entries |
| wrEn | input | 1 | Load an entry |
| wrIdx | input | 6 | Slot to load |
| wrVpn | input | 35 | Virtual page number tag |
| wrCtx | input | 13 | Context tag |
| wrPpn | input | 28 | Physical page number |
| wrValid | input | 1 | Valid flag |
| wrGlobal | input | 1 | Context is ignored |
| wrSize | input | 2 | Page size code |
| wrPriv | input | 1 | Privileged-only page |
| wrWritable | input | 1 | Write permission |
| wrSideEff | input | 1 | Side-effect page |
| wrNoFault | input | 1 | No-fault-only page |
| wrInvEnd | input | 1 | Invert endianness |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 48 | Virtual address |
| lkCtxSel | input | 2 | Context selector |
| lkKind | input | 2 | 0 load, 1 store, 2 non-faulting load, 3 load |
| lkUser | input | 1 | Requester is in user mode |
| primaryCtx | input | 13 | Primary context value |
| secondaryCtx | input | 13 | Secondary context value |
| sfsrClr | input | 1 | Clear the fault status word |
| victimIdx | output | 6 | Suggested refill slot |
| rspValid | output | 1 | A lookup result is present |
| rspHit | output | 1 | The lookup hit |
| rspPa | output | 41 | Physical address |
| rspWritable | output | 1 | The hit entry is writable |
| rspByteSwap | output | 1 | The hit entry inverts endianness |
| rspMiss | output | 1 | Miss trap |
| rspFault | output | 1 | Data fault trap |
| rspProt | output | 1 | Write-protection trap |
| sfsr | output | 9 | Fault status word |
| sfar | output | 48 | Fault address |
| tagAccess | output | 48 | Page and context of the last trapped lookup |

## Verification
The used flags cannot be read directly. They show up only through the victim index, and only once every slot is valid. The bench therefore fills all 64 slots first. It then drives a clean hit, a trapped hit and a rewrite, and watches `victimIdx` move forward, stay put and fall back. The same-cycle write-versus-lookup case and the clear-with-fault case are hard to reach from the ports, so the bench drives both sets of inputs on one clock edge.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int PG_SHIFT  = 13;  // smallest page is 8 KB
  localparam int SIZE_STEP = 3;   // each size code widens the page by 8x

  localparam int SF_W       = 9;
  localparam int SF_VALID   = 0;
  localparam int SF_OVF     = 1;
  localparam int SF_STORE   = 2;
  localparam int SF_CTX_LO  = 3;
  localparam int SF_PRIV    = 5;
  localparam int SF_FT_PRIV = 6;
  localparam int SF_FT_SE   = 7;
  localparam int SF_FT_NFO  = 8;

  typedef enum logic [1:0] {
    KIND_LOAD = 2'd0, KIND_STORE = 2'd1, KIND_NFLOAD = 2'd2, KIND_OTHER = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    CSEL_PRIMARY = 2'd0, CSEL_SECONDARY = 2'd1, CSEL_NUCLEUS = 2'd2, CSEL_SPARE = 2'd3
  } ctxSel_e;

  typedef struct packed {
    logic hit;
    logic priv;
    logic writable;
    logic sideEff;
    logic noFault;
    logic invEnd;
  } hitInfo_t;

  typedef struct packed {
    logic markUsed;
  } ctlStrobe_t;
endpackage

// File: rtl/dtlb_datapath.sv
module dtlb_datapath
  import dtlb_pkg::*;
#(
  parameter int NUM_ENT = 64,
  parameter int VA_W    = 48,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [$clog2(NUM_ENT)-1:0]    wrIdx,
  input  logic [VA_W-PG_SHIFT-1:0]      wrVpn,
  input  logic [CTX_W-1:0]              wrCtx,
  input  logic [PA_W-PG_SHIFT-1:0]      wrPpn,
  input  logic                          wrValid,
  input  logic                          wrGlobal,
  input  logic [1:0]                    wrSize,
  input  logic                          wrPriv,
  input  logic                          wrWritable,
  input  logic                          wrSideEff,
  input  logic                          wrNoFault,
  input  logic                          wrInvEnd,
  input  logic [VA_W-PG_SHIFT-1:0]      lkVpn,
  input  logic [CTX_W-1:0]              lkCtx,
  input  ctlStrobe_t                    strobe,
  output hitInfo_t                      hitInfo,
  output logic [PA_W-1:0]               hitPa,
  output logic [$clog2(NUM_ENT)-1:0]    victimIdx
);
  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;

  typedef struct packed {
    logic             valid;
    logic             global;
    logic [1:0]       size;
    logic             priv;
    logic             writable;
    logic             sideEff;
    logic             noFault;
    logic             invEnd;
    logic             used;
    logic [CTX_W-1:0] ctx;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } entry_t;

  entry_t               ent [NUM_ENT];
  logic [NUM_ENT-1:0]   matchVec;
  logic [IDX_W-1:0]     hitIdx;
  logic                 anyHit;
  logic [VPN_W-1:0]     selMask;
  logic [PPN_W-1:0]     ppnKeep;

  for (genvar i = 0; i < NUM_ENT; i++) begin : gCmp
    logic [VPN_W-1:0] cmpMask;
    assign cmpMask     = {VPN_W{1'b1}} << (SIZE_STEP * ent[i].size);
    assign matchVec[i] = ent[i].valid && (ent[i].global || ent[i].ctx == lkCtx)
                         && (((lkVpn ^ ent[i].vpn) & cmpMask) == '0);
  end

  always_comb begin
    hitIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  always_comb begin
    selMask = {VPN_W{1'b1}} << (SIZE_STEP * ent[hitIdx].size);
    ppnKeep = selMask[PPN_W-1:0];
    hitPa   = {(ent[hitIdx].ppn & ppnKeep) | (lkVpn[PPN_W-1:0] & ~ppnKeep),
               {PG_SHIFT{1'b0}}};
    hitInfo = '{hit:      anyHit,
                priv:     ent[hitIdx].priv,
                writable: ent[hitIdx].writable,
                sideEff:  ent[hitIdx].sideEff,
                noFault:  ent[hitIdx].noFault,
                invEnd:   ent[hitIdx].invEnd};
  end

  always_comb begin
    logic foundFree, foundFresh;
    logic [IDX_W-1:0] freeIdx, freshIdx;
    foundFree  = 1'b0;
    foundFresh = 1'b0;
    freeIdx    = '0;
    freshIdx   = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!ent[i].valid) begin
        foundFree = 1'b1;
        freeIdx   = IDX_W'(i);
      end
      if (!ent[i].used) begin
        foundFresh = 1'b1;
        freshIdx   = IDX_W'(i);
      end
    end
    victimIdx = foundFree ? freeIdx : (foundFresh ? freshIdx : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENT; i++) ent[i] <= '0;
    end else begin
      if (strobe.markUsed) ent[hitIdx].used <= 1'b1;
      if (wrEn) begin
        ent[wrIdx] <= '{valid: wrValid, global: wrGlobal, size: wrSize, priv: wrPriv,
                        writable: wrWritable, sideEff: wrSideEff, noFault: wrNoFault,
                        invEnd: wrInvEnd, used: 1'b0, ctx: wrCtx, vpn: wrVpn, ppn: wrPpn};
      end
    end
  end

  // R10: a clean hit leaves the matched slot marked as used
  p_used_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markUsed && !(wrEn && wrIdx == hitIdx) |=> ent[$past(hitIdx)].used);
endmodule

// File: rtl/dtlb_control.sv
module dtlb_control
  import dtlb_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 41,
  parameter int CTX_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [1:0]        lkCtxSel,
  input  logic [1:0]        lkKind,
  input  logic              lkUser,
  input  logic [CTX_W-1:0]  primaryCtx,
  input  logic [CTX_W-1:0]  secondaryCtx,
  input  logic              sfsrClr,
  input  hitInfo_t          hitInfo,
  input  logic [PA_W-1:0]   hitPa,
  output logic [CTX_W-1:0]  lkCtx,
  output ctlStrobe_t        strobe,
  output logic              rspValid,
  output logic              rspHit,
  output logic [PA_W-1:0]   rspPa,
  output logic              rspWritable,
  output logic              rspByteSwap,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspProt,
  output logic [SF_W-1:0]   sfsr,
  output logic [VA_W-1:0]   sfar,
  output logic [VA_W-1:0]   tagAccess
);
  logic isStore, isNf, ftPriv, ftSe, ftNfo, anyFt;
  logic faultNow, protNow, missNow, lkHit;
  logic [SF_W-1:0] sfsrNext;

  always_comb begin
    case (ctxSel_e'(lkCtxSel))
      CSEL_PRIMARY:   lkCtx = primaryCtx;
      CSEL_SECONDARY: lkCtx = secondaryCtx;
      default:        lkCtx = '0;
    endcase
  end

  always_comb begin
    isStore  = accKind_e'(lkKind) == KIND_STORE;
    isNf     = accKind_e'(lkKind) == KIND_NFLOAD;
    lkHit    = lkValid && hitInfo.hit;
    ftPriv   = hitInfo.priv && lkUser;
    ftSe     = hitInfo.sideEff && isNf;
    ftNfo    = hitInfo.noFault && !isNf;
    anyFt    = ftPriv || ftSe || ftNfo;
    faultNow = lkHit && anyFt;
    protNow  = lkHit && !anyFt && isStore && !hitInfo.writable;
    missNow  = lkValid && !hitInfo.hit;
    strobe.markUsed = lkHit && !anyFt && !protNow;

    sfsrNext = '0;
    sfsrNext[SF_VALID]        = 1'b1;
    sfsrNext[SF_OVF]          = sfsr[SF_VALID] && !sfsrClr;
    sfsrNext[SF_STORE]        = isStore;
    sfsrNext[SF_CTX_LO +: 2]  = lkCtxSel;
    sfsrNext[SF_PRIV]         = !lkUser;
    sfsrNext[SF_FT_PRIV]      = ftPriv;
    sfsrNext[SF_FT_SE]        = ftSe;
    sfsrNext[SF_FT_NFO]       = ftNfo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspPa       <= '0;
      rspWritable <= 1'b0;
      rspByteSwap <= 1'b0;
      rspMiss     <= 1'b0;
      rspFault    <= 1'b0;
      rspProt     <= 1'b0;
      sfsr        <= '0;
      sfar        <= '0;
      tagAccess   <= '0;
    end else begin
      rspValid    <= lkValid;
      rspHit      <= lkHit;
      rspPa       <= lkHit ? hitPa : '0;
      rspWritable <= lkHit && hitInfo.writable;
      rspByteSwap <= lkHit && hitInfo.invEnd;
      rspMiss     <= missNow;
      rspFault    <= faultNow;
      rspProt     <= protNow;
      if (faultNow || protNow) begin
        sfsr <= sfsrNext;
        sfar <= lkVa;
      end else if (sfsrClr) begin
        sfsr <= '0;
      end
      if (faultNow || protNow || missNow)
        tagAccess <= {lkVa[VA_W-1:PG_SHIFT], {(PG_SHIFT-CTX_W){1'b0}}, lkCtx};
    end
  end

  // R8: a trap that finds an unread status word flags overflow
  p_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultNow || protNow) && sfsr[SF_VALID] && !sfsrClr |=> sfsr[SF_OVF]);

  // R9: a miss leaves status and fault address alone
  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    missNow && !sfsrClr |=> $stable(sfsr) && $stable(sfar));

  // R7: the three trap outputs never coincide
  p_trap_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspMiss, rspFault, rspProt}));

  // R7: a protection trap only follows a store
  p_prot_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspProt |-> $past(lkKind) == KIND_STORE);

  // R5: a reported fault always leaves a valid status word
  p_fault_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> sfsr[SF_VALID]);
endmodule

// File: rtl/dtlb_top.sv
module dtlb_top
  import dtlb_pkg::*;
#(
  parameter int NUM_ENT = 64,
  parameter int VA_W    = 48,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [$clog2(NUM_ENT)-1:0]  wrIdx,
  input  logic [VA_W-PG_SHIFT-1:0]    wrVpn,
  input  logic [CTX_W-1:0]            wrCtx,
  input  logic [PA_W-PG_SHIFT-1:0]    wrPpn,
  input  logic                        wrValid,
  input  logic                        wrGlobal,
  input  logic [1:0]                  wrSize,
  input  logic                        wrPriv,
  input  logic                        wrWritable,
  input  logic                        wrSideEff,
  input  logic                        wrNoFault,
  input  logic                        wrInvEnd,
  input  logic                        lkValid,
  input  logic [VA_W-1:0]             lkVa,
  input  logic [1:0]                  lkCtxSel,
  input  logic [1:0]                  lkKind,
  input  logic                        lkUser,
  input  logic [CTX_W-1:0]            primaryCtx,
  input  logic [CTX_W-1:0]            secondaryCtx,
  input  logic                        sfsrClr,
  output logic [$clog2(NUM_ENT)-1:0]  victimIdx,
  output logic                        rspValid,
  output logic                        rspHit,
  output logic [PA_W-1:0]             rspPa,
  output logic                        rspWritable,
  output logic                        rspByteSwap,
  output logic                        rspMiss,
  output logic                        rspFault,
  output logic                        rspProt,
  output logic [SF_W-1:0]             sfsr,
  output logic [VA_W-1:0]             sfar,
  output logic [VA_W-1:0]             tagAccess
);
  hitInfo_t         hitInfo;
  ctlStrobe_t       strobe;
  logic [PA_W-1:0]  hitPa;
  logic [CTX_W-1:0] lkCtx;

  dtlb_datapath #(.NUM_ENT(NUM_ENT), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)) uDp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrCtx(wrCtx), .wrPpn(wrPpn),
    .wrValid(wrValid), .wrGlobal(wrGlobal), .wrSize(wrSize), .wrPriv(wrPriv),
    .wrWritable(wrWritable), .wrSideEff(wrSideEff), .wrNoFault(wrNoFault),
    .wrInvEnd(wrInvEnd),
    .lkVpn(lkVa[VA_W-1:PG_SHIFT]), .lkCtx(lkCtx), .strobe(strobe),
    .hitInfo(hitInfo), .hitPa(hitPa), .victimIdx(victimIdx)
  );

  dtlb_control #(.VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)) uCtl (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkVa(lkVa), .lkCtxSel(lkCtxSel), .lkKind(lkKind),
    .lkUser(lkUser), .primaryCtx(primaryCtx), .secondaryCtx(secondaryCtx),
    .sfsrClr(sfsrClr), .hitInfo(hitInfo), .hitPa(hitPa),
    .lkCtx(lkCtx), .strobe(strobe),
    .rspValid(rspValid), .rspHit(rspHit), .rspPa(rspPa), .rspWritable(rspWritable),
    .rspByteSwap(rspByteSwap), .rspMiss(rspMiss), .rspFault(rspFault),
    .rspProt(rspProt), .sfsr(sfsr), .sfar(sfar), .tagAccess(tagAccess)
  );
endmodule

// File: tb/tb_dtlb_top.sv
module tb_dtlb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 48;
  localparam int PA_W = 41;
  localparam int VPN_W = 35;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrValid = 0, wrGlobal = 0, wrPriv = 0, wrWritable = 0;
  logic wrSideEff = 0, wrNoFault = 0, wrInvEnd = 0;
  logic [5:0] wrIdx = '0;
  logic [VPN_W-1:0] wrVpn = '0;
  logic [12:0] wrCtx = '0;
  logic [27:0] wrPpn = '0;
  logic [1:0] wrSize = '0;
  logic lkValid = 0, lkUser = 0, sfsrClr = 0;
  logic [VA_W-1:0] lkVa = '0;
  logic [1:0] lkCtxSel = '0, lkKind = '0;
  logic [12:0] primaryCtx = 13'd7, secondaryCtx = 13'd8;
  logic [5:0] victimIdx;
  logic rspValid, rspHit, rspWritable, rspByteSwap, rspMiss, rspFault, rspProt;
  logic [PA_W-1:0] rspPa;
  logic [8:0] sfsr;
  logic [VA_W-1:0] sfar, tagAccess;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtlb_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrCtx(wrCtx),
    .wrPpn(wrPpn), .wrValid(wrValid), .wrGlobal(wrGlobal), .wrSize(wrSize),
    .wrPriv(wrPriv), .wrWritable(wrWritable), .wrSideEff(wrSideEff),
    .wrNoFault(wrNoFault), .wrInvEnd(wrInvEnd), .lkValid(lkValid), .lkVa(lkVa),
    .lkCtxSel(lkCtxSel), .lkKind(lkKind), .lkUser(lkUser), .primaryCtx(primaryCtx),
    .secondaryCtx(secondaryCtx), .sfsrClr(sfsrClr), .victimIdx(victimIdx),
    .rspValid(rspValid), .rspHit(rspHit), .rspPa(rspPa), .rspWritable(rspWritable),
    .rspByteSwap(rspByteSwap), .rspMiss(rspMiss), .rspFault(rspFault),
    .rspProt(rspProt), .sfsr(sfsr), .sfar(sfar), .tagAccess(tagAccess)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] mkVa(input logic [VPN_W-1:0] vpn, input logic [12:0] off);
    return {vpn, off};
  endfunction

  task automatic putEntry(input int idx, input logic [VPN_W-1:0] vpn, input logic [12:0] ctx,
                          input logic [27:0] ppn, input logic vld, input logic glb,
                          input logic [1:0] sz, input logic prv, input logic wrt,
                          input logic se, input logic nfo, input logic ie);
    @(negedge clk);
    wrEn = 1; wrIdx = 6'(idx); wrVpn = vpn; wrCtx = ctx; wrPpn = ppn; wrValid = vld;
    wrGlobal = glb; wrSize = sz; wrPriv = prv; wrWritable = wrt; wrSideEff = se;
    wrNoFault = nfo; wrInvEnd = ie;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic lookup(input logic [VA_W-1:0] va, input logic [1:0] sel,
                        input logic [1:0] kind, input logic user, input logic clr);
    @(negedge clk);
    lkValid = 1; lkVa = va; lkCtxSel = sel; lkKind = kind; lkUser = user; sfsrClr = clr;
    @(negedge clk);
    lkValid = 0; sfsrClr = 0;
  endtask

  task automatic clearStatus();
    @(negedge clk); sfsrClr = 1;
    @(negedge clk); sfsrClr = 0;
  endtask

  task automatic testReset();
    check("R1", "rspValid after reset", 64'(rspValid), 0);
    check("R8", "sfsr after reset", 64'(sfsr), 0);
    check("R10", "victim after reset", 64'(victimIdx), 0);
  endtask

  task automatic testBasicHit();
    putEntry(5, 35'h12345, 13'd7, 28'hABCDE, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    lookup(mkVa(35'h12345, 13'h123), 2'd0, 2'd0, 1, 0);
    check("R1", "rspValid", 64'(rspValid), 1);
    check("R1", "hit primary", 64'(rspHit), 1);
    check("R2", "8K pa", 64'(rspPa), 64'(28'hABCDE) << 13);
    check("R1", "writable", 64'(rspWritable), 1);
    lookup(mkVa(35'h12345, 13'h0), 2'd1, 2'd0, 1, 0);
    check("R3", "secondary ctx mismatch misses", 64'(rspHit), 0);
    check("R9", "miss trap", 64'(rspMiss), 1);
    check("R9", "tagAccess on miss", 64'(tagAccess), (64'h12345 << 13) | 64'd8);
    check("R9", "sfsr untouched on miss", 64'(sfsr), 0);
    check("R9", "sfar untouched on miss", 64'(sfar), 0);
    lookup(mkVa(35'h12344, 13'h0), 2'd0, 2'd0, 1, 0);
    check("R1", "vpn mismatch misses", 64'(rspMiss), 1);
  endtask

  task automatic testPageSizes();
    putEntry(6, 35'h40000, 13'd7, 28'h01235FF, 1, 0, 2'd3, 0, 1, 0, 0, 0);
    putEntry(7, 35'h50008, 13'd7, 28'h0000770, 1, 0, 2'd1, 0, 1, 0, 0, 0);
    putEntry(8, 35'h60000, 13'd7, 28'h0001000, 1, 0, 2'd2, 0, 1, 0, 0, 0);
    lookup(mkVa(35'h400AB, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R2", "4M hit", 64'(rspHit), 1);
    check("R2", "4M pa", 64'(rspPa), 64'(28'h01234AB) << 13);
    lookup(mkVa(35'h40200, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R2", "4M outside page misses", 64'(rspMiss), 1);
    lookup(mkVa(35'h5000D, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R2", "64K pa", 64'(rspPa), 64'(28'h0000775) << 13);
    lookup(mkVa(35'h50010, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R2", "64K outside page misses", 64'(rspMiss), 1);
    lookup(mkVa(35'h6003F, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R2", "512K pa", 64'(rspPa), 64'(28'h000103F) << 13);
    lookup(mkVa(35'h60040, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R2", "512K outside page misses", 64'(rspMiss), 1);
  endtask

  task automatic testContexts();
    putEntry(9, 35'h70000, 13'd3, 28'h9, 1, 1, 2'd0, 0, 1, 0, 0, 0);
    putEntry(10, 35'h71000, 13'd0, 28'hA, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    lookup(mkVa(35'h70000, 13'h0), 2'd2, 2'd0, 0, 0);
    check("R3", "global hit under nucleus", 64'(rspPa), 64'h9 << 13);
    lookup(mkVa(35'h70000, 13'h0), 2'd1, 2'd0, 0, 0);
    check("R3", "global hit under secondary", 64'(rspHit), 1);
    lookup(mkVa(35'h71000, 13'h0), 2'd2, 2'd0, 0, 0);
    check("R3", "nucleus uses ctx 0", 64'(rspPa), 64'hA << 13);
    lookup(mkVa(35'h71000, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R3", "ctx 0 entry misses under primary", 64'(rspMiss), 1);
  endtask

  task automatic testPriority();
    putEntry(20, 35'h72000, 13'd7, 28'h20, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    putEntry(21, 35'h72000, 13'd7, 28'h21, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    lookup(mkVa(35'h72000, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R4", "lowest index wins", 64'(rspPa), 64'h20 << 13);
    putEntry(20, 35'h72000, 13'd7, 28'h20, 0, 0, 2'd0, 0, 1, 0, 0, 0);
    lookup(mkVa(35'h72000, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R4", "next match after invalidate", 64'(rspPa), 64'h21 << 13);
  endtask

  task automatic testPrivFault();
    putEntry(11, 35'h73000, 13'd7, 28'hB, 1, 0, 2'd0, 1, 1, 0, 0, 0);
    lookup(mkVa(35'h73000, 13'h456), 2'd0, 2'd0, 1, 0);
    check("R5", "user to priv faults", 64'(rspFault), 1);
    check("R8", "sfsr priv fault", 64'(sfsr), 64'h041);
    check("R8", "sfar", 64'(sfar), 64'(mkVa(35'h73000, 13'h456)));
    check("R8", "tagAccess on fault", 64'(tagAccess), (64'h73000 << 13) | 64'd7);
    lookup(mkVa(35'h73000, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R5", "supervisor access clean", 64'(rspFault), 0);
    check("R5", "supervisor access hits", 64'(rspHit), 1);
    lookup(mkVa(35'h73000, 13'h0), 2'd0, 2'd1, 1, 0);
    check("R8", "overflow and store bit", 64'(sfsr), 64'h047);
    clearStatus();
    check("R13", "clear empties status", 64'(sfsr), 0);
  endtask

  task automatic testSideEffects();
    secondaryCtx = 13'd7;
    putEntry(12, 35'h74000, 13'd7, 28'hC, 1, 0, 2'd0, 1, 1, 1, 1, 0);
    lookup(mkVa(35'h74000, 13'h0), 2'd1, 2'd2, 1, 0);
    check("R6", "nf load: priv and side-effect bits", 64'(sfsr), 64'h0C9);
    check("R6", "fault trap", 64'(rspFault), 1);
    lookup(mkVa(35'h74000, 13'h0), 2'd0, 2'd0, 0, 1);
    check("R6", "load to nfo page", 64'(rspFault), 1);
    check("R13", "clear with fault: no overflow", 64'(sfsr), 64'h121);
    clearStatus();
    secondaryCtx = 13'd8;
  endtask

  task automatic testProtect();
    putEntry(13, 35'h75000, 13'd7, 28'hD, 1, 0, 2'd0, 0, 0, 0, 0, 0);
    lookup(mkVa(35'h75000, 13'h10), 2'd0, 2'd1, 0, 0);
    check("R7", "store to ro prot trap", 64'(rspProt), 1);
    check("R7", "no fault trap", 64'(rspFault), 0);
    check("R7", "writable low", 64'(rspWritable), 0);
    check("R8", "sfsr on prot", 64'(sfsr), 64'h025);
    check("R8", "sfar on prot", 64'(sfar), 64'(mkVa(35'h75000, 13'h10)));
    lookup(mkVa(35'h75000, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R7", "load to ro page clean", 64'(rspProt), 0);
    clearStatus();
  endtask

  task automatic testByteSwap();
    putEntry(14, 35'h76000, 13'd7, 28'hE, 1, 0, 2'd0, 0, 1, 0, 0, 1);
    lookup(mkVa(35'h76000, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R11", "invert-endian reports swap", 64'(rspByteSwap), 1);
    lookup(mkVa(35'h12345, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R11", "plain entry no swap", 64'(rspByteSwap), 0);
  endtask

  task automatic testVictimAndWrite();
    check("R10", "victim is lowest invalid", 64'(victimIdx), 0);
    for (int i = 0; i < 64; i++)
      putEntry(i, 35'h100 + 35'(i), 13'd7, 28'h200 + 28'(i), 1, 0, 2'd0, 0, 1, 0, 0, 0);
    check("R10", "all valid, none used", 64'(victimIdx), 0);
    lookup(mkVa(35'h100, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R10", "clean hit marks used", 64'(victimIdx), 1);
    putEntry(1, 35'h101, 13'd7, 28'h201, 1, 0, 2'd0, 1, 1, 0, 0, 0);
    lookup(mkVa(35'h101, 13'h0), 2'd0, 2'd0, 1, 0);
    check("R10", "faulted hit not used", 64'(victimIdx), 1);
    lookup(mkVa(35'h101, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R10", "clean hit moves victim", 64'(victimIdx), 2);
    putEntry(0, 35'h100, 13'd7, 28'h200, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    check("R12", "rewrite clears used", 64'(victimIdx), 0);
    @(negedge clk);
    wrEn = 1; wrIdx = 6'd2; wrVpn = 35'h999; wrCtx = 13'd7; wrPpn = 28'h999; wrValid = 1;
    wrGlobal = 0; wrSize = 0; wrPriv = 0; wrWritable = 1; wrSideEff = 0; wrNoFault = 0;
    wrInvEnd = 0;
    lkValid = 1; lkVa = mkVa(35'h102, 13'h0); lkCtxSel = 0; lkKind = 0; lkUser = 0;
    @(negedge clk);
    wrEn = 0; lkValid = 0;
    check("R12", "same-cycle lookup sees old entry", 64'(rspPa), 64'h202 << 13);
    lookup(mkVa(35'h102, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R12", "old tag gone", 64'(rspMiss), 1);
    lookup(mkVa(35'h999, 13'h0), 2'd0, 2'd0, 0, 0);
    check("R12", "new tag hits", 64'(rspPa), 64'h999 << 13);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicHit();
    testPageSizes();
    testContexts();
    testPriority();
    testPrivFault();
    testSideEffects();
    testProtect();
    testByteSwap();
    testVictimAndWrite();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule